// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the host-side controller for a 3-wire, 10-bit successive-approximation ADC. It starts a conversion on request, drives the converter's active-low chip select and serial clock, samples the serial data line, and presents each finished frame to system logic. The frame carries a 10-bit result, two sub-LSB bits and a channel identifier.

The converter picks its conversion clock from the SCLK level it sees when chip select falls. The `int_mode` input chooses between the two options, and the controller sets SCLK to match before it asserts chip select.
- **External mode:** SCLK also runs the conversion.
- **Internal mode:** the controller gives one falling edge to start the conversion. It then waits for the converter to raise its data line as an end-of-conversion marker before it reads the frame.

Four values are programmable in system-clock cycles: the SCLK half period, the wake-up wait after chip select falls, the minimum chip-select high time, and the end-of-conversion timeout. Each frame is checked for its fixed leading ones. The channel identifier can optionally be checked to confirm that it alternates from one frame to the next. The frame is also given as two bytes for hosts that work a byte at a time.

Top module: `serial_adc_reader`

## Requirements
- R1: When chip select falls, SCLK is low if the conversion was started with `int_mode`=0 (external clock) and high if it was started with `int_mode`=1 (internal clock).
- R2: After chip select falls, SCLK does not change for at least `wake_cyc` system cycles.
- R3: Every SCLK high phase while chip select is low lasts exactly `half_cyc` system cycles (0 is treated as 1). `adc_dout` is sampled in the system cycle in which SCLK rises.
- R4: Frame sequence:
  - In external mode, one lead pulse is followed by 16 capture pulses.
  - In internal mode, one falling edge is followed by a wait for `adc_dout`=1, and then 16 capture pulses.
  - Chip select rises only after the last falling edge.
  - The 16 captured bits, in arrival order, are three ones, the channel ID, D9 down to D0, then S1 and S0.
- R5: Chip select stays high for at least `gap_cyc` system cycles before it falls again, including the first conversion after reset.
- R6: `valid` pulses for one system cycle when a frame completes. It is raised in the same cycle as chip select.
  - `result`, `sub_bits`, `chan_id`, `frame_err`, `byte_hi` and `byte_lo` change only in that cycle and hold until the next `valid`.
  - `byte_hi` holds the first 8 captured bits and `byte_lo` the last 8, each MSB first.
- R7: `frame_err` is 1 for a frame whose first three captured bits are not all ones.
- R8: When `alt_check`=1, `frame_err` is also 1 for a frame whose channel ID equals that of the previous completed frame. The first frame after reset is never flagged this way, and nothing is flagged when `alt_check`=0.
- R9: In internal mode, if `adc_dout` is not seen high within `eoc_limit` system cycles of the conversion-start edge, the controller does three things:
  - it raises chip select;
  - it pulses `timeout` for one cycle;
  - it gives no `valid` and leaves all result outputs unchanged.
- R10: `start` is ignored while a conversion is in progress. A `start` that arrives during the chip-select high time is held until that time has elapsed.
- R11: During and after reset, chip select is high, SCLK is low, and `valid`, `timeout`, `frame_err` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request |
| int_mode | input | 1 | 1 selects the converter's internal clock, 0 the external clock |
| alt_check | input | 1 | Enables the channel-alternation check |
| half_cyc | input | CW | SCLK half period in system cycles |
| wake_cyc | input | CW | Wake-up wait after chip select falls |
| gap_cyc | input | CW | Minimum chip-select high time |
| eoc_limit | input | CW | End-of-conversion timeout |
| adc_dout | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| result | output | 10 | Conversion result |
| sub_bits | output | 2 | Sub-LSB bits S1, S0 |
| chan_id | output | 1 | Channel identifier of the frame |
| byte_hi | output | 8 | First captured byte |
| byte_lo | output | 8 | Second captured byte |
| valid | output | 1 | One-cycle frame-complete strobe |
| frame_err | output | 1 | Frame check failed |
| timeout | output | 1 | One-cycle end-of-conversion timeout strobe |

## Verification
**Shift position:** A capture counter that is off by one shifts the whole frame by one bit. This shows up in the very next result as a broken leading-ones pattern or a wrong channel bit.

**Phase timing:** A timing counter that ends one of its phases early moves an SCLK edge or a chip-select fall earlier. The converter model times every edge against chip select, so this is caught in the same conversion.

**Mode and alternation state:** A wrong latched mode shows up at the chip-select fall as the wrong SCLK level. Corrupt alternation state shows up as `frame_err` on the frame after the one that set it.

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          int_mode,
  input  logic          alt_check,
  input  logic [CW-1:0] half_cyc,
  input  logic [CW-1:0] wake_cyc,
  input  logic [CW-1:0] gap_cyc,
  input  logic [CW-1:0] eoc_limit,
  input  logic          adc_dout,
  output logic          cs_n,
  output logic          sclk,
  output logic [9:0]    result,
  output logic [1:0]    sub_bits,
  output logic          chan_id,
  output logic [7:0]    byte_hi,
  output logic [7:0]    byte_lo,
  output logic          valid,
  output logic          frame_err,
  output logic          timeout
);
  localparam int NB  = 16;
  localparam int NBW = $clog2(NB + 1);

  typedef enum logic [2:0] {IDLE, PREP, WAKE, LEAD, EOCW, SHIFT, FIN} st_t;

  st_t            st;
  logic [CW-1:0]  tmr, gcnt;
  logic [NBW-1:0] nbit;
  logic [NB-1:0]  sh;
  logic           pend, mode_q, prev_id, have_prev;

  wire [CW:0] tnx      = {1'b0, tmr} + {{CW{1'b0}}, 1'b1};
  wire        hit_half = tnx >= {1'b0, half_cyc};
  wire        hit_wake = tnx >= {1'b0, wake_cyc};
  wire        hit_tmo  = tnx >= {1'b0, eoc_limit};
  wire        gap_ok   = gcnt >= gap_cyc;
  wire        lead_bad = sh[NB-1 -: 3] != 3'b111;
  wire        alt_bad  = alt_check && have_prev && (sh[12] == prev_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      tmr       <= '0;
      gcnt      <= '0;
      nbit      <= '0;
      sh        <= '0;
      pend      <= 1'b0;
      mode_q    <= 1'b0;
      prev_id   <= 1'b0;
      have_prev <= 1'b0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      result    <= '0;
      sub_bits  <= '0;
      chan_id   <= 1'b0;
      byte_hi   <= '0;
      byte_lo   <= '0;
      valid     <= 1'b0;
      frame_err <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      if (start && st == IDLE) pend <= 1'b1;
      case (st)
        IDLE: begin
          if (gcnt != {CW{1'b1}}) gcnt <= gcnt + 1'b1;
          if ((pend || start) && gap_ok) begin
            pend   <= 1'b0;
            mode_q <= int_mode;
            sclk   <= int_mode;
            tmr    <= '0;
            st     <= PREP;
          end
        end
        PREP: begin
          tmr <= tmr + 1'b1;
          if (hit_half) begin
            cs_n <= 1'b0;
            tmr  <= '0;
            st   <= WAKE;
          end
        end
        WAKE: begin
          tmr <= tmr + 1'b1;
          if (hit_wake) begin
            tmr  <= '0;
            sclk <= ~mode_q;
            st   <= mode_q ? EOCW : LEAD;
          end
        end
        LEAD: begin
          tmr <= tmr + 1'b1;
          if (hit_half) begin
            sclk <= 1'b0;
            tmr  <= '0;
            nbit <= '0;
            st   <= SHIFT;
          end
        end
        EOCW: begin
          tmr <= tmr + 1'b1;
          if (adc_dout) begin
            tmr  <= '0;
            nbit <= '0;
            st   <= SHIFT;
          end else if (hit_tmo) begin
            cs_n    <= 1'b1;
            timeout <= 1'b1;
            gcnt    <= '0;
            st      <= IDLE;
          end
        end
        SHIFT: begin
          tmr <= tmr + 1'b1;
          if (hit_half) begin
            tmr  <= '0;
            sclk <= ~sclk;
            if (!sclk) begin
              sh   <= {sh[NB-2:0], adc_dout};
              nbit <= nbit + 1'b1;
            end else if (nbit == NBW'(NB)) begin
              st <= FIN;
            end
          end
        end
        FIN: begin
          cs_n      <= 1'b1;
          gcnt      <= '0;
          valid     <= 1'b1;
          result    <= sh[11:2];
          sub_bits  <= sh[1:0];
          chan_id   <= sh[12];
          byte_hi   <= sh[15:8];
          byte_lo   <= sh[7:0];
          frame_err <= lead_bad || alt_bad;
          prev_id   <= sh[12];
          have_prev <= 1'b1;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_adc_reader_chk.sv
module serial_adc_reader_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk,
  input logic          mode_q,
  input logic [CW-1:0] wake_cyc,
  input logic [CW-1:0] gap_cyc,
  input logic          valid,
  input logic          timeout,
  input logic          frame_err,
  input logic [9:0]    result,
  input logic [1:0]    sub_bits,
  input logic          chan_id,
  input logic [7:0]    byte_hi,
  input logic [7:0]    byte_lo
);
  logic [CW:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else begin
      lo_cnt <= cs_n ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !cs_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  a_r1_mode_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk == mode_q);

  a_r2_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(sclk)) |-> lo_cnt >= {1'b0, wake_cyc});

  a_r4_cs_up_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> cs_n);

  a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= {1'b0, gap_cyc});

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable({result, sub_bits, chan_id, frame_err, byte_hi, byte_lo}));

  a_r7_lead_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && byte_hi[7:5] != 3'b111) |-> frame_err);

  a_r9_timeout_abort: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cs_n && !valid));
endmodule

bind serial_adc_reader serial_adc_reader_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_serial_adc_reader.sv
module tb_serial_adc_reader;
  localparam int CW = 16;
  localparam int HALF = 3, WAKE = 250, GAP = 6, TMO = 200, CONV = 80;

  logic clk = 0, rst_n = 0, start = 0, int_mode = 0, alt_check = 1;
  logic [CW-1:0] half_cyc = HALF, wake_cyc = WAKE, gap_cyc = GAP, eoc_limit = TMO;
  logic adc_dout;
  logic cs_n, sclk, chan_id, valid, frame_err, timeout;
  logic [9:0] result;
  logic [1:0] sub_bits;
  logic [7:0] byte_hi, byte_lo;

  always #5 clk = ~clk;

  serial_adc_reader #(.CW(CW)) dut (.*);

  int nvec = 0, nerr = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // converter model
  logic m_ch = 0, m_mode = 0, m_dout = 0, conv_go = 0, conv_done = 0;
  logic m_bad = 0, m_stuck = 0, no_toggle = 0, exp_mode = 0;
  logic [9:0] m_data = 0;
  logic [1:0] m_sub = 0;
  int fcnt = 0, conv_cnt = 0, v_wake = 0, v_gap = 0, v_rate = 0, v_mode = 0, cs_falls = 0;
  time t_fall = 0, t_rise = 0, t_sck = 0;
  bit sck_ok = 0;
  assign adc_dout = m_dout;

  function automatic logic bitk(input int k);
    logic [15:0] fr;
    fr = {(m_bad ? 3'b101 : 3'b111), m_ch, m_data, m_sub};
    return (k >= 1 && k <= 16) ? fr[16-k] : 1'b0;
  endfunction

  always @(negedge cs_n) begin
    cs_falls++;
    m_mode = sclk; fcnt = 0; conv_go = 0; conv_done = 0; conv_cnt = 0;
    if (sclk !== exp_mode) v_mode++;
    if ($time - t_rise < GAP * 10) v_gap++;
    t_fall = $time; sck_ok = 0;
  end
  always @(posedge cs_n) begin
    t_rise = $time; m_dout <= 0; conv_cnt = 0;
    if (fcnt >= 16 && !no_toggle) m_ch = ~m_ch;
  end
  always @(posedge sclk) if (cs_n === 1'b0) begin
    if ($time - t_fall < WAKE * 10) v_wake++;
    t_sck = $time; sck_ok = 1;
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    if ($time - t_fall < WAKE * 10) v_wake++;
    if (sck_ok && ($time - t_sck != HALF * 10)) v_rate++;
    if (!m_mode) begin fcnt++; m_dout <= bitk(fcnt); end
    else if (!conv_go) begin conv_go = 1; conv_cnt = CONV; end
    else if (conv_done) begin fcnt++; m_dout <= bitk(fcnt); end
  end
  always @(posedge clk) if (conv_cnt > 0) begin
    if (conv_cnt == 1 && !m_stuck && !cs_n) begin conv_done = 1; fcnt = 1; m_dout <= bitk(1); end
    conv_cnt--;
  end

  // scoreboard
  typedef struct packed {
    logic kind; logic ch; logic [9:0] data; logic [1:0] sub; logic ferr; logic [7:0] bh, bl;
  } item_t;
  item_t q[$];
  int pushed = 0, popped = 0;
  logic have_prev = 0, prev_ch = 0;
  logic [9:0] last_res = 0;

  task automatic conv(input logic im, input logic [9:0] d, input logic [1:0] s,
                      input logic bad, input logic stuck);
    item_t it;
    logic [15:0] fr;
    m_data = d; m_sub = s; m_bad = bad; m_stuck = stuck; exp_mode = im;
    fr = {(bad ? 3'b101 : 3'b111), m_ch, d, s};
    it.kind = stuck; it.ch = m_ch; it.data = d; it.sub = s;
    it.ferr = bad | (alt_check & have_prev & (m_ch == prev_ch));
    it.bh = fr[15:8]; it.bl = fr[7:0];
    if (!stuck) begin have_prev = 1; prev_ch = m_ch; end
    q.push_back(it); pushed++;
    @(negedge clk); int_mode = im; start = 1;
    @(negedge clk); start = 0;
    wait (popped == pushed);
  endtask

  always @(negedge clk) if (rst_n && (valid || timeout)) begin
    if (q.size() == 0) chk(0, "R10 unexpected frame", 1, 0);
    else begin
      item_t e;
      e = q.pop_front();
      if (e.kind) begin
        chk(timeout && !valid, "R9 timeout strobe", {valid, timeout}, 1);
        chk(cs_n, "R9 cs raised", cs_n, 1);
        chk(result == last_res, "R9 result kept", result, last_res);
      end else begin
        chk(valid && !timeout, "R6 valid strobe", {valid, timeout}, 2);
        chk(result == e.data, "R4 result", result, e.data);
        chk(sub_bits == e.sub, "R4 sub bits", sub_bits, e.sub);
        chk(chan_id == e.ch, "R4 channel id", chan_id, e.ch);
        chk(frame_err == e.ferr, "R7/R8 frame_err", frame_err, e.ferr);
        chk({byte_hi, byte_lo} == {e.bh, e.bl}, "R6 bytes", {byte_hi, byte_lo}, {e.bh, e.bl});
        last_res = e.data;
      end
      popped++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nvec++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0, "R11 reset pins", {cs_n, sclk}, 2);
    chk(valid == 0 && timeout == 0 && frame_err == 0, "R11 reset flags", {valid, timeout, frame_err}, 0);
    chk(result == 0 && byte_hi == 0 && byte_lo == 0, "R11 reset data", result, 0);
    rst_n = 1;
    @(negedge clk);
    conv(0, 10'h000, 2'b00, 0, 0);          // R4 external
    conv(0, 10'h3FF, 2'b11, 0, 0);
    conv(1, 10'h2AA, 2'b01, 0, 0);          // R4 internal
    conv(1, 10'h155, 2'b10, 0, 0);
    conv(0, 10'h0F0, 2'b00, 1, 0);          // R7 bad lead
    no_toggle = 1;
    conv(0, 10'h123, 2'b01, 0, 0);
    no_toggle = 0;
    conv(0, 10'h321, 2'b10, 0, 0);          // R8 repeated id
    alt_check = 0; no_toggle = 1;
    conv(0, 10'h0AB, 2'b11, 0, 0);
    no_toggle = 0;
    conv(0, 10'h0CD, 2'b00, 0, 0);          // R8 check off
    alt_check = 1;
    conv(1, 10'h111, 2'b01, 0, 1);          // R9 timeout
    conv(1, 10'h2F0, 2'b10, 0, 0);
    begin
      int falls0;
      falls0 = cs_falls;
      fork
        conv(0, 10'h1C3, 2'b01, 0, 0);      // R10 busy start
        begin repeat (300) @(negedge clk); start = 1; @(negedge clk); start = 0; end
      join
      repeat (800) @(negedge clk);
      chk(cs_falls == falls0 + 1 && cs_n, "R10 start ignored while busy", cs_falls - falls0, 1);
    end
    chk(v_mode == 0, "R1 sclk level at cs fall", v_mode, 0);
    chk(v_wake == 0, "R2 wake wait", v_wake, 0);
    chk(v_rate == 0, "R3 sclk high time", v_rate, 0);
    chk(v_gap == 0, "R5 cs high time", v_gap, 0);
    chk(q.size() == 0, "R6 all frames delivered", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule